// File: doc/BRIEF.md
# Interrupt Vector Routing Controller

The block collects seven level-type interrupt requests and steers each one onto one of eight output interrupt lines. Requests arrive as events: an index plus the new level. A status bit per request holds that level. Each request belongs to one of six vector registers. A vector register holds a 16-bit server number, an 8-bit priority and a 3-bit source number. The source number chooses the output line. Requests 0 and 1 share vector 0 and its line. That line stays high while either of the two is active.

Software programs the vector registers through a single-cycle write port. It can read back any vector, or either status word, through a combinational read port. A priority of all ones masks a vector. The pending flag of a vector shows whether its request was active and unmasked when the last event for it arrived. Acknowledge does not clear this flag. For each vector, the block drives the routing configuration in force: the server number with its two link-pointer bits removed, and the priority. A write that names a source number outside the routable range is kept in the register but is not put into force. That write raises a one-cycle error pulse, and so does an event with an unknown index.

Top module: `ivr_router`

## Requirements
- R1: After reset, every vector register v reads priority 0xFF, source number v, server 0 and pending 0. All output lines are low, both status words read zero, err_o is low, and every exported priority is 0xFF. In a vector word, bits 55:40 hold the server, bits 39:32 the priority, bits 31:29 the source number and bit 24 the pending flag; every other bit reads zero.
- R2: An event (ev_valid, ev_idx, ev_level) with ev_idx below 7 sets that request's status bit to ev_level from the next clock edge. Request 1 is bit 47 and request 0 is bit 46 of the control status word (rd_sel 6). Requests 2 to 6 are bits 36 down to 32 of the interrupt status word (rd_sel 7). All other bits read zero.
- R3: Output line n is high whenever some vector whose routed source number is n has an active request. If several vectors route to the same line, the line is the OR of their activity. An active request drives its line whether its vector is masked or not.
- R4: Requests 0 and 1 both use vector 0. Its line and its activity stay high until both status bits are low.
- R5: When an event for vector v arrives, pending becomes 1 if the vector is still active afterwards and its priority is not 0xFF. Otherwise pending becomes 0.
- R6: A write to rd/wr select 0 to 5 replaces the server, priority and source number of that vector and keeps its pending flag. The exception is a priority of 0xFF in the write, which clears pending in the same edge.
- R7: For each vector, vec_server_o carries the routed server number shifted right by 2, and vec_prio_o carries the routed priority. Both change only on a write.
- R8: A vector write with a source number of 6 or 7 is stored and reads back. Routing, vec_server_o and vec_prio_o keep their previous values, and err_o is high for the one cycle after that write.
- R9: An event with ev_idx 7 changes no status bit, no pending flag and no line, and err_o is high for the one cycle after it.
- R10: A write with select 6 or 7 has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Request level event strobe |
| ev_idx | input | 3 | Request index of the event |
| ev_level | input | 1 | New level of that request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register written (0..5 vectors) |
| wr_data | input | 64 | Write data in the vector word layout |
| rd_sel | input | 3 | Register read (0..5 vectors, 6 control status, 7 interrupt status) |
| rd_data | output | 64 | Read data, combinational |
| irq_lines_o | output | 8 | Output interrupt lines indexed by source number |
| vec_server_o | output | 84 | Routed server number per vector, 14 bits each, vector 0 lowest |
| vec_prio_o | output | 48 | Routed priority per vector, 8 bits each, vector 0 lowest |
| err_o | output | 1 | One-cycle pulse after a bad event index or a bad source write |

## Verification
The properties assume that an event and a write are never presented in the same cycle. Under that assumption, one registered error pulse and a change in a routed output can each be tied to a single cause. The stimulus issues exactly one operation per strobe cycle and idles between operations. The random mix covers every event index, including the unknown one. It also covers every write select and source number, and gives a masking priority about a quarter of the time.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int SRV_W  = 16;
   localparam int PRIO_W = 8;
   localparam int SRC_W  = 3;
   localparam int WORD_W = 64;
   // field positions in a vector word
   localparam int SRV_LSB  = 40;
   localparam int PRIO_LSB = 32;
   localparam int SRC_LSB  = 29;
   localparam int PEND_BIT = 24;
   // status word positions
   localparam int CTL_LINK_BIT = 46;
   localparam int CTL_SVC_BIT  = 47;
   localparam int STAT_TOP_BIT = 36;

   typedef struct packed {
      logic [SRV_W-1:0]  srv;
      logic [PRIO_W-1:0] prio;
      logic [SRC_W-1:0]  src;
   } vec_cfg_t;

   function automatic vec_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
      vec_cfg_t c;
      c.srv  = w[SRV_LSB  +: SRV_W];
      c.prio = w[PRIO_LSB +: PRIO_W];
      c.src  = w[SRC_LSB  +: SRC_W];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] pack_word(input vec_cfg_t c, input logic pend);
      logic [WORD_W-1:0] w;
      w = '0;
      w[SRV_LSB  +: SRV_W]  = c.srv;
      w[PRIO_LSB +: PRIO_W] = c.prio;
      w[SRC_LSB  +: SRC_W]  = c.src;
      w[PEND_BIT]           = pend;
      return w;
   endfunction
endpackage

// File: rtl/ivr_status.sv
module ivr_status #(
   parameter int NUM_REQ = 7,
   localparam int IDX_W  = $clog2(NUM_REQ + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid,
   input  logic [IDX_W-1:0]   ev_idx,
   input  logic               ev_level,
   output logic [NUM_REQ-1:0] stat_q,
   output logic [NUM_REQ-1:0] stat_nxt,
   output logic [NUM_REQ-1:0] hit,
   output logic               bad_idx
);
   assign bad_idx = ev_valid && (int'(ev_idx) >= NUM_REQ);

   for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
      assign hit[k]      = ev_valid && (int'(ev_idx) == k);
      assign stat_nxt[k] = hit[k] ? ev_level : stat_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_nxt;
   end
endmodule

// File: rtl/ivr_vector.sv
module ivr_vector import ivr_pkg::*; #(
   parameter int VEC_ID  = 0,
   parameter int NUM_SRC = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr,
   input  vec_cfg_t wr_cfg,
   input  logic     ev_hit,
   input  logic     active_nxt,
   output vec_cfg_t cfg_q,
   output vec_cfg_t route_q,
   output logic     pend_q,
   output logic     bad_src
);
   localparam vec_cfg_t RST_CFG = '{srv: '0, prio: '1, src: SRC_W'(VEC_ID)};

   logic masked_new;

   assign bad_src    = wr && (int'(wr_cfg.src) >= NUM_SRC);
   assign masked_new = wr ? (&wr_cfg.prio) : (&cfg_q.prio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= RST_CFG;
         route_q <= RST_CFG;
         pend_q  <= 1'b0;
      end else begin
         if (wr) cfg_q <= wr_cfg;
         if (wr && !bad_src) route_q <= wr_cfg;
         if (ev_hit)  pend_q <= active_nxt && !masked_new;
         else if (wr) pend_q <= pend_q && !masked_new;
      end
   end
endmodule

// File: rtl/ivr_line_or.sv
module ivr_line_or #(
   parameter int NUM_VEC   = 6,
   parameter int NUM_LINES = 8,
   parameter int SRC_W     = 3
) (
   input  logic [NUM_VEC-1:0]           active,
   input  logic [NUM_VEC-1:0][SRC_W-1:0] src,
   output logic [NUM_LINES-1:0]         lines
);
   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      always_comb begin
         lines[n] = 1'b0;
         for (int v = 0; v < NUM_VEC; v++)
            if (active[v] && (int'(src[v]) == n)) lines[n] = 1'b1;
      end
   end
endmodule

// File: rtl/ivr_router.sv
module ivr_router import ivr_pkg::*; #(
   parameter int NUM_VEC   = 6,
   parameter int NUM_LINES = 8,
   parameter int LINK_BITS = 2,
   localparam int NUM_REQ  = NUM_VEC + 1,
   localparam int IDX_W    = $clog2(NUM_REQ + 1),
   localparam int SEL_W    = $clog2(NUM_VEC + 2),
   localparam int SRVX_W   = SRV_W - LINK_BITS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ev_valid,
   input  logic [IDX_W-1:0]            ev_idx,
   input  logic                        ev_level,
   input  logic                        wr_en,
   input  logic [SEL_W-1:0]            wr_sel,
   input  logic [WORD_W-1:0]           wr_data,
   input  logic [SEL_W-1:0]            rd_sel,
   output logic [WORD_W-1:0]           rd_data,
   output logic [NUM_LINES-1:0]        irq_lines_o,
   output logic [NUM_VEC*SRVX_W-1:0]   vec_server_o,
   output logic [NUM_VEC*PRIO_W-1:0]   vec_prio_o,
   output logic                        err_o
);
   if (NUM_LINES != (1 << SRC_W)) begin : g_chk_lines
      $error("NUM_LINES must match the source field width");
   end
   if (NUM_VEC < 2 || NUM_VEC > NUM_LINES) begin : g_chk_vec
      $error("NUM_VEC out of range");
   end
   if (LINK_BITS < 0 || LINK_BITS >= SRV_W) begin : g_chk_link
      $error("LINK_BITS out of range");
   end
   if (STAT_TOP_BIT - (NUM_REQ - 3) < 0) begin : g_chk_stat
      $error("too many requests for the status word");
   end

   logic [NUM_REQ-1:0] stat_q, stat_nxt, hit;
   logic               bad_idx;

   ivr_status #(.NUM_REQ(NUM_REQ)) u_status (
      .clk, .rst_n, .ev_valid, .ev_idx, .ev_level,
      .stat_q, .stat_nxt, .hit, .bad_idx
   );

   vec_cfg_t                       wr_cfg;
   vec_cfg_t [NUM_VEC-1:0]         cfg_q, route_q;
   logic [NUM_VEC-1:0]             pend_q, bad_src, active, active_nxt, vhit, vwr;
   logic [NUM_VEC-1:0][SRC_W-1:0]  route_src;
   logic                           unused_wr_bits;

   assign wr_cfg         = unpack_cfg(wr_data);
   assign unused_wr_bits = ^{wr_data[WORD_W-1:SRV_LSB+SRV_W], wr_data[SRC_LSB-1:0]};

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      if (v == 0) begin : g_shared
         // requests 0 and 1 share vector 0
         assign active[v]     = stat_q[0]   | stat_q[1];
         assign active_nxt[v] = stat_nxt[0] | stat_nxt[1];
         assign vhit[v]       = hit[0]      | hit[1];
      end else begin : g_single
         assign active[v]     = stat_q[v+1];
         assign active_nxt[v] = stat_nxt[v+1];
         assign vhit[v]       = hit[v+1];
      end
      assign vwr[v] = wr_en && (int'(wr_sel) == v);

      ivr_vector #(.VEC_ID(v), .NUM_SRC(NUM_VEC)) u_vec (
         .clk, .rst_n, .wr(vwr[v]), .wr_cfg,
         .ev_hit(vhit[v]), .active_nxt(active_nxt[v]),
         .cfg_q(cfg_q[v]), .route_q(route_q[v]),
         .pend_q(pend_q[v]), .bad_src(bad_src[v])
      );

      assign route_src[v]                      = route_q[v].src;
      assign vec_server_o[v*SRVX_W +: SRVX_W]  = route_q[v].srv[SRV_W-1:LINK_BITS];
      assign vec_prio_o[v*PRIO_W +: PRIO_W]    = route_q[v].prio;
   end

   ivr_line_or #(.NUM_VEC(NUM_VEC), .NUM_LINES(NUM_LINES), .SRC_W(SRC_W)) u_lines (
      .active, .src(route_src), .lines(irq_lines_o)
   );

   // status words
   logic [WORD_W-1:0] ctl_word, irq_word;
   always_comb begin
      ctl_word = '0;
      ctl_word[CTL_LINK_BIT] = stat_q[0];
      ctl_word[CTL_SVC_BIT]  = stat_q[1];
   end
   for (genvar k = 2; k < NUM_REQ; k++) begin : g_irqw
      assign irq_word[STAT_TOP_BIT-(k-2)] = stat_q[k];
   end
   for (genvar b = 0; b < WORD_W; b++) begin : g_irqz
      if (b > STAT_TOP_BIT || b < STAT_TOP_BIT - (NUM_REQ - 3)) begin : g_z
         assign irq_word[b] = 1'b0;
      end
   end

   always_comb begin
      rd_data = irq_word;
      if (int'(rd_sel) < NUM_VEC)       rd_data = pack_word(cfg_q[rd_sel], pend_q[rd_sel]);
      else if (int'(rd_sel) == NUM_VEC) rd_data = ctl_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_o <= 1'b0;
      else        err_o <= bad_idx || (|bad_src);
   end
endmodule

// File: rtl/ivr_router_chk.sv
module ivr_router_chk import ivr_pkg::*; #(
   parameter int NUM_VEC   = 6,
   parameter int NUM_LINES = 8,
   parameter int LINK_BITS = 2,
   localparam int NUM_REQ  = NUM_VEC + 1,
   localparam int IDX_W    = $clog2(NUM_REQ + 1),
   localparam int SEL_W    = $clog2(NUM_VEC + 2),
   localparam int SRVX_W   = SRV_W - LINK_BITS
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ev_valid,
   input logic [IDX_W-1:0]          ev_idx,
   input logic                      wr_en,
   input logic [SEL_W-1:0]          wr_sel,
   input logic [WORD_W-1:0]         wr_data,
   input logic [NUM_LINES-1:0]      irq_lines_o,
   input logic [NUM_VEC*SRVX_W-1:0] vec_server_o,
   input logic [NUM_VEC*PRIO_W-1:0] vec_prio_o,
   input logic                      err_o
);
   logic bad_ev, bad_wr;
   assign bad_ev = ev_valid && (int'(ev_idx) >= NUM_REQ);
   assign bad_wr = wr_en && (int'(wr_sel) < NUM_VEC) &&
                   (int'(wr_data[SRC_LSB +: SRC_W]) >= NUM_VEC);

   AST_LINES_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_lines_o == '0));                                  // R1
   AST_BAD_IDX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      bad_ev |=> err_o);                                                      // R9
   AST_BAD_IDX_NO_LINE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_ev && !wr_en) |=> $stable(irq_lines_o));                           // R9
   AST_BAD_SRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> err_o);                                                      // R8
   AST_BAD_SRC_ROUTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_wr && !ev_valid) |=> ($stable(vec_server_o) && $stable(vec_prio_o))); // R8
   AST_NO_ERR_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bad_ev && !bad_wr) |=> !err_o);                                       // R8
   AST_ROUTE_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(vec_prio_o) && $stable(vec_server_o)));             // R7
   AST_HIGH_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_sel) >= NUM_VEC && !ev_valid) |=>
      ($stable(vec_prio_o) && $stable(vec_server_o) && $stable(irq_lines_o))); // R10
endmodule

bind ivr_router ivr_router_chk #(
   .NUM_VEC(NUM_VEC), .NUM_LINES(NUM_LINES), .LINK_BITS(LINK_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_idx(ev_idx),
   .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .irq_lines_o(irq_lines_o), .vec_server_o(vec_server_o),
   .vec_prio_o(vec_prio_o), .err_o(err_o)
);

// File: tb/ivr_router_test.sv
module ivr_router_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;
   localparam int NR = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [2:0]  ev_idx = '0;
   logic        ev_level = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [63:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [63:0] rd_data;
   logic [7:0]  irq_lines_o;
   logic [83:0] vec_server_o;
   logic [47:0] vec_prio_o;
   logic        err_o;

   ivr_router uut (
      .clk, .rst_n, .ev_valid, .ev_idx, .ev_level, .wr_en, .wr_sel, .wr_data,
      .rd_sel, .rd_data, .irq_lines_o, .vec_server_o, .vec_prio_o, .err_o
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference model
   bit          m_stat [NR];
   logic [15:0] m_srv [NV];
   logic [7:0]  m_prio [NV];
   logic [2:0]  m_src [NV];
   bit          m_pend [NV];
   logic [15:0] r_srv [NV];
   logic [7:0]  r_prio [NV];
   logic [2:0]  r_src [NV];
   bit          m_err;

   function automatic bit vec_active(int v);
      return (v == 0) ? (m_stat[0] | m_stat[1]) : m_stat[v+1];
   endfunction

   function automatic logic [7:0] exp_lines();
      logic [7:0] l = '0;
      for (int v = 0; v < NV; v++) if (vec_active(v)) l[r_src[v]] = 1'b1;
      return l;
   endfunction

   function automatic logic [63:0] exp_word(int s);
      logic [63:0] w = '0;
      if (s < NV) begin
         w[55:40] = m_srv[s]; w[39:32] = m_prio[s]; w[31:29] = m_src[s]; w[24] = m_pend[s];
      end else if (s == NV) begin
         w[47] = m_stat[1]; w[46] = m_stat[0];
      end else begin
         for (int k = 2; k < NR; k++) w[36-(k-2)] = m_stat[k];
      end
      return w;
   endfunction

   task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check(tag, "lines", 128'(irq_lines_o), 128'(exp_lines()));
      check(tag, "err", 128'(err_o), 128'(m_err));
      for (int v = 0; v < NV; v++) begin
         check(tag, $sformatf("server%0d", v), 128'(vec_server_o[v*14 +: 14]), 128'(r_srv[v] >> 2));
         check(tag, $sformatf("prio%0d", v), 128'(vec_prio_o[v*8 +: 8]), 128'(r_prio[v]));
      end
      for (int s = 0; s < 8; s++) begin
         rd_sel = 3'(s);
         #1;
         check(tag, $sformatf("read%0d", s), 128'(rd_data), 128'(exp_word(s)));
      end
   endtask

   task automatic do_event(int idx, bit lvl, string tag);
      @(negedge clk);
      ev_valid = 1'b1; ev_idx = 3'(idx); ev_level = lvl;
      @(negedge clk);
      ev_valid = 1'b0;
      m_err = (idx >= NR);
      if (idx < NR) begin
         int v = (idx <= 1) ? 0 : idx - 1;
         m_stat[idx] = lvl;
         m_pend[v] = vec_active(v) && (m_prio[v] != 8'hFF);
      end
      check_all(tag);
   endtask

   task automatic do_write(int sel, logic [15:0] srv, logic [7:0] prio, logic [2:0] src, string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel);
      wr_data = {$urandom, $urandom};
      wr_data[55:40] = srv; wr_data[39:32] = prio; wr_data[31:29] = src;
      @(negedge clk);
      wr_en = 1'b0;
      m_err = 1'b0;
      if (sel < NV) begin
         m_srv[sel] = srv; m_prio[sel] = prio; m_src[sel] = src;
         m_pend[sel] = m_pend[sel] && (prio != 8'hFF);
         if (src < 3'(NV)) begin
            r_srv[sel] = srv; r_prio[sel] = prio; r_src[sel] = src;
         end else m_err = 1'b1;
      end
      check_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1bad5eed));
      for (int k = 0; k < NR; k++) m_stat[k] = 0;
      for (int v = 0; v < NV; v++) begin
         m_srv[v] = '0; m_prio[v] = 8'hFF; m_src[v] = 3'(v); m_pend[v] = 0;
         r_srv[v] = '0; r_prio[v] = 8'hFF; r_src[v] = 3'(v);
      end
      m_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // status bits and masked request still drives line, pending stays 0
      do_event(3, 1, "R2");
      do_event(6, 1, "R3");
      do_event(3, 0, "R2");
      do_event(6, 0, "R5");
      // server shift, update, pending keep
      do_write(2, 16'hABCD, 8'h05, 3'd2, "R7");
      do_event(3, 1, "R5");
      do_write(2, 16'h1237, 8'h06, 3'd4, "R6");
      do_write(2, 16'h1237, 8'hFF, 3'd4, "R6");
      do_event(3, 0, "R5");
      // shared vector: line held until both idle
      do_write(0, 16'h0010, 8'h01, 3'd0, "R6");
      do_event(0, 1, "R4");
      do_event(1, 1, "R4");
      do_event(0, 0, "R4");
      do_event(1, 0, "R4");
      // two vectors on one line
      do_write(4, 16'h0004, 8'h02, 3'd1, "R3");
      do_event(5, 1, "R3");
      do_event(2, 1, "R3");
      do_event(5, 0, "R3");
      do_event(2, 0, "R3");
      // bad source write, bad index, high select
      do_write(1, 16'hFFFF, 8'h03, 3'd6, "R8");
      do_write(5, 16'h8000, 8'h00, 3'd7, "R8");
      do_event(7, 1, "R9");
      do_write(6, 16'h5555, 8'h00, 3'd3, "R10");
      do_write(7, 16'h5555, 8'h00, 3'd3, "R10");

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(1, 0) == 0)
            do_event($urandom_range(7, 0), 1'($urandom_range(1, 0)), "R2/R3/R5/R9");
         else
            do_write($urandom_range(7, 0), 16'($urandom),
                     ($urandom_range(3, 0) == 0) ? 8'hFF : 8'($urandom),
                     ($urandom_range(4, 0) == 0) ? 3'($urandom_range(7, 6)) : 3'($urandom_range(5, 0)),
                     "R6/R7/R8/R10");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule